// File: doc/BRIEF.md
# Neighbor-Assisted Page Recovery Controller

This controller takes over after an ordinary page read has failed its ECC decode. Before the trigger, the system loads four page buffers through a shared write port:

- the page that failed;
- the LSB page of the adjacent (aggressor) wordline;
- the MSB page of the adjacent (aggressor) wordline;
- a scratch buffer that receives re-read data.

Once started, the controller works through the four possible two-bit neighbor values in a fixed order. For each value it does the following:

1. It issues one flash read request. The request carries a reference-level code taken from a small programmable table.
2. It waits for the re-read data to arrive.
3. It merges that data into the failed page, word by word. A cell takes the re-read bit only if its neighbor cell holds the value currently being tried.
4. It hands the merged page to ECC.

A passing decode ends the flow with `done_o` held high. If the fourth value also fails, the flow ends with `fail_o` held high, and the last merged page stays in the buffer.

The controller is a single state machine with these states:

| State | Role |
|---|---|
| `ST_IDLE` | Waiting for a trigger |
| `ST_REQ` | One-cycle read request |
| `ST_WAIT` | Waiting for re-read data |
| `ST_MERGE` | One word per cycle |
| `ST_CHECK` | ECC submitted, waiting for the result |
| `ST_PASS` | Terminal, recovery succeeded |
| `ST_GIVEUP` | Terminal, all values tried |

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | `ST_IDLE`, `ST_PASS` or `ST_GIVEUP` | `ST_REQ` | `start_i`; the trial index is reset to 0 |
| issue | `ST_REQ` | `ST_WAIT` | always, after one cycle |
| data_in | `ST_WAIT` | `ST_MERGE` | `rd_done_i` |
| merged | `ST_MERGE` | `ST_CHECK` | the last word has been written |
| ok | `ST_CHECK` | `ST_PASS` | `ecc_ack_i` with `ecc_ok_i` high |
| retry | `ST_CHECK` | `ST_REQ` | `ecc_ack_i` with `ecc_ok_i` low, and the trial index is below 3; the index is incremented |
| exhausted | `ST_CHECK` | `ST_GIVEUP` | `ecc_ack_i` with `ecc_ok_i` low on trial 3 |

The data buffers are never reset. The ECC engine reads the merged page through a separate read port.

Top module: `nac_recovery_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `ecc_req_o`, `done_o` and `fail_o` are low. No read request is issued until `start_i` is seen, and writes to the buffers do not start the flow.
- R2: Each neighbor value is written {LSB,MSB}. The cell states are erased = 11, P1 = 10, P2 = 00 and P3 = 01. The values are tried in the order 11, 10, 01, 00: trial k uses the value equal to the bitwise inverse of k.
- R3: Each trial issues exactly one read request, a single-cycle pulse on `rd_req_o`. During that pulse, `rd_lvl_o` equals the level-table entry whose index is the neighbor value being tried; writing entry i via `lvl_we_i` and `lvl_idx_i` changes what later requests carry.
- R4: In the merge, bit i of a word in the failed page takes the re-read bit i only when the neighbor LSB bit i and the neighbor MSB bit i equal the value being tried. All other bits keep their buffered value. Merges accumulate across trials.
- R5: The merge writes one word per cycle. `ecc_req_o` rises exactly PAGE_BITS/WORD_W cycles after the cycle in which `rd_done_i` is sampled, and stays high until `ecc_ack_i`.
- R6: An ECC acknowledge with `ecc_ok_i` high raises `done_o` on the next cycle. No further read requests follow, and the merged page can be read on `page_raddr_i`/`page_rdata_o`.
- R7: An ECC acknowledge with `ecc_ok_i` low moves on to the next neighbor value. After the fourth failure, `fail_o` is raised and the page buffer holds the result of all four merges.
- R8: A `start_i` given after `done_o` or `fail_o` clears that output and restarts the sequence from value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | ECC-fail trigger that starts recovery |
| lvl_we_i | input | 1 | Level-table write enable |
| lvl_idx_i | input | 2 | Level-table entry (neighbor value) |
| lvl_val_i | input | LVL_W | Level code to store |
| buf_we_i | input | 1 | Buffer word write enable |
| buf_sel_i | input | 2 | Buffer select: 0 failed page, 1 neighbor LSB, 2 neighbor MSB, 3 re-read |
| buf_addr_i | input | AW | Word address for the buffer write |
| buf_wdata_i | input | WORD_W | Buffer write data |
| page_raddr_i | input | AW | Word address for the page read port |
| page_rdata_o | output | WORD_W | Failed or merged page word |
| rd_req_o | output | 1 | Flash re-read request pulse |
| rd_lvl_o | output | LVL_W | Reference-level code for the request |
| rd_done_i | input | 1 | Re-read data is in the scratch buffer |
| ecc_req_o | output | 1 | Merged page submitted to ECC |
| ecc_ack_i | input | 1 | ECC result is valid |
| ecc_ok_i | input | 1 | ECC decode succeeded |
| done_o | output | 1 | Recovery succeeded |
| fail_o | output | 1 | All four values tried without success |

## Verification
The bound checker covers the handshake rules on every cycle:

- the read request is a one-cycle pulse that only follows a trigger or a failed decode;
- the ECC request is held until it is acknowledged;
- request and terminal outputs are exclusive;
- a retry steps down to the next neighbor value;
- `done_o` and `fail_o` rise only after a passing decode or after the final failing decode, respectively.

The bench scenarios are needed to show the bit-level merge contents, the accumulation across trials, the level codes drawn from a reprogrammed table, and the exact length of the merge window. Those depend on data values that a cycle-local property cannot predict.

// File: rtl/nac_pkg.sv
package nac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_MERGE,
        ST_CHECK,
        ST_PASS,
        ST_GIVEUP
    } nac_state_e;

    localparam logic [1:0] BUF_PAGE = 2'd0;
    localparam logic [1:0] BUF_NLSB = 2'd1;
    localparam logic [1:0] BUF_NMSB = 2'd2;
    localparam logic [1:0] BUF_RRD  = 2'd3;

    localparam int unsigned NUM_TRIALS = 4;

endpackage

// File: rtl/nac_level_table.sv
module nac_level_table #(
    parameter int unsigned LVL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [1:0]       widx_i,
    input  logic [LVL_W-1:0] wval_i,
    input  logic [1:0]       ridx_i,
    output logic [LVL_W-1:0] rval_o
);

    logic [LVL_W-1:0] tbl_q [nac_pkg::NUM_TRIALS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(nac_pkg::NUM_TRIALS); i++) begin
                tbl_q[i] <= LVL_W'(i);
            end
        end else if (we_i) begin
            tbl_q[widx_i] <= wval_i;
        end
    end

    assign rval_o = tbl_q[ridx_i];

endmodule

// File: rtl/nac_page_store.sv
module nac_page_store #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned AW     = 2
) (
    input  logic              clk_i,
    input  logic              ext_we_i,
    input  logic [1:0]        ext_sel_i,
    input  logic [AW-1:0]     ext_addr_i,
    input  logic [WORD_W-1:0] ext_wdata_i,
    input  logic              mrg_we_i,
    input  logic [AW-1:0]     mrg_addr_i,
    input  logic [WORD_W-1:0] mrg_wdata_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [WORD_W-1:0] page_m_o,
    output logic [WORD_W-1:0] nlsb_m_o,
    output logic [WORD_W-1:0] nmsb_m_o,
    output logic [WORD_W-1:0] rrd_m_o,
    output logic [WORD_W-1:0] page_rd_o
);

    logic [WORD_W-1:0] mem_q [4][WORDS];

    always_ff @(posedge clk_i) begin
        for (int b = 0; b < 4; b++) begin
            if (mrg_we_i && b == int'(nac_pkg::BUF_PAGE)) begin
                mem_q[b][mrg_addr_i] <= mrg_wdata_i;
            end else if (ext_we_i && ext_sel_i == 2'(b)) begin
                mem_q[b][ext_addr_i] <= ext_wdata_i;
            end
        end
    end

    assign page_m_o  = mem_q[nac_pkg::BUF_PAGE][mrg_addr_i];
    assign nlsb_m_o  = mem_q[nac_pkg::BUF_NLSB][mrg_addr_i];
    assign nmsb_m_o  = mem_q[nac_pkg::BUF_NMSB][mrg_addr_i];
    assign rrd_m_o   = mem_q[nac_pkg::BUF_RRD][mrg_addr_i];
    assign page_rd_o = mem_q[nac_pkg::BUF_PAGE][rd_addr_i];

endmodule

// File: rtl/nac_cell_merge.sv
module nac_cell_merge #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [1:0]        val_i,
    input  logic [WORD_W-1:0] page_i,
    input  logic [WORD_W-1:0] nlsb_i,
    input  logic [WORD_W-1:0] nmsb_i,
    input  logic [WORD_W-1:0] rrd_i,
    output logic [WORD_W-1:0] merged_o
);

    logic [WORD_W-1:0] hit;

    for (genvar i = 0; i < int'(WORD_W); i++) begin : g_cell
        // per-cell comparator on the neighbor {LSB,MSB} pair
        assign hit[i]      = (nlsb_i[i] == val_i[1]) && (nmsb_i[i] == val_i[0]);
        // pass gate from re-read data into the page word
        assign merged_o[i] = hit[i] ? rrd_i[i] : page_i[i];
    end

endmodule

// File: rtl/nac_seq_fsm.sv
module nac_seq_fsm
    import nac_pkg::*;
#(
    parameter int unsigned WORDS = 4,
    parameter int unsigned AW    = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          rd_done_i,
    input  logic          ecc_ack_i,
    input  logic          ecc_ok_i,
    output logic          rd_req_o,
    output logic          ecc_req_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          mrg_we_o,
    output logic [AW-1:0] mrg_addr_o,
    output logic [1:0]    cur_val_o
);

    localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);
    localparam logic [1:0]    LAST_TRY  = 2'(NUM_TRIALS - 1);

    nac_state_e    state_q, state_d;
    logic [1:0]    try_q, try_d;
    logic [AW-1:0] wcnt_q, wcnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            try_q   <= '0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            try_q   <= try_d;
            wcnt_q  <= wcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        try_d   = try_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_GIVEUP: begin
                if (start_i) begin
                    state_d = ST_REQ;
                    try_d   = '0;
                end
            end
            ST_REQ: state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_done_i) begin
                    state_d = ST_MERGE;
                    wcnt_d  = '0;
                end
            end
            ST_MERGE: begin
                wcnt_d = wcnt_q + AW'(1);
                if (wcnt_q == LAST_WORD) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (ecc_ack_i) begin
                    if (ecc_ok_i) begin
                        state_d = ST_PASS;
                    end else if (try_q == LAST_TRY) begin
                        state_d = ST_GIVEUP;
                    end else begin
                        state_d = ST_REQ;
                        try_d   = try_q + 2'd1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req_o   = (state_q == ST_REQ);
        ecc_req_o  = (state_q == ST_CHECK);
        done_o     = (state_q == ST_PASS);
        fail_o     = (state_q == ST_GIVEUP);
        mrg_we_o   = (state_q == ST_MERGE);
        mrg_addr_o = wcnt_q;
        cur_val_o  = ~try_q;
    end

endmodule

// File: rtl/nac_recovery_ctrl.sv
module nac_recovery_ctrl #(
    parameter int unsigned PAGE_BITS = 64,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned LVL_W     = 4,
    localparam int unsigned WORDS    = PAGE_BITS / WORD_W,
    localparam int unsigned AW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              lvl_we_i,
    input  logic [1:0]        lvl_idx_i,
    input  logic [LVL_W-1:0]  lvl_val_i,
    input  logic              buf_we_i,
    input  logic [1:0]        buf_sel_i,
    input  logic [AW-1:0]     buf_addr_i,
    input  logic [WORD_W-1:0] buf_wdata_i,
    input  logic [AW-1:0]     page_raddr_i,
    output logic [WORD_W-1:0] page_rdata_o,
    output logic              rd_req_o,
    output logic [LVL_W-1:0]  rd_lvl_o,
    input  logic              rd_done_i,
    output logic              ecc_req_o,
    input  logic              ecc_ack_i,
    input  logic              ecc_ok_i,
    output logic              done_o,
    output logic              fail_o
);

    logic              mrg_we;
    logic [AW-1:0]     mrg_addr;
    logic [1:0]        cur_val;
    logic [WORD_W-1:0] page_m, nlsb_m, nmsb_m, rrd_m, merged;

    nac_seq_fsm #(.WORDS(WORDS), .AW(AW)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .rd_done_i  (rd_done_i),
        .ecc_ack_i  (ecc_ack_i),
        .ecc_ok_i   (ecc_ok_i),
        .rd_req_o   (rd_req_o),
        .ecc_req_o  (ecc_req_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .mrg_we_o   (mrg_we),
        .mrg_addr_o (mrg_addr),
        .cur_val_o  (cur_val)
    );

    nac_level_table #(.LVL_W(LVL_W)) u_lvl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (lvl_we_i),
        .widx_i (lvl_idx_i),
        .wval_i (lvl_val_i),
        .ridx_i (cur_val),
        .rval_o (rd_lvl_o)
    );

    nac_page_store #(.WORD_W(WORD_W), .WORDS(WORDS), .AW(AW)) u_store (
        .clk_i       (clk_i),
        .ext_we_i    (buf_we_i),
        .ext_sel_i   (buf_sel_i),
        .ext_addr_i  (buf_addr_i),
        .ext_wdata_i (buf_wdata_i),
        .mrg_we_i    (mrg_we),
        .mrg_addr_i  (mrg_addr),
        .mrg_wdata_i (merged),
        .rd_addr_i   (page_raddr_i),
        .page_m_o    (page_m),
        .nlsb_m_o    (nlsb_m),
        .nmsb_m_o    (nmsb_m),
        .rrd_m_o     (rrd_m),
        .page_rd_o   (page_rdata_o)
    );

    nac_cell_merge #(.WORD_W(WORD_W)) u_merge (
        .val_i    (cur_val),
        .page_i   (page_m),
        .nlsb_i   (nlsb_m),
        .nmsb_i   (nmsb_m),
        .rrd_i    (rrd_m),
        .merged_o (merged)
    );

endmodule

// File: rtl/nac_recovery_chk.sv
module nac_recovery_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic       rd_req_o,
    input logic       ecc_req_o,
    input logic       ecc_ack_i,
    input logic       ecc_ok_i,
    input logic       done_o,
    input logic       fail_o,
    input logic [1:0] cur_val
);

    p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o);

    p_req_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_req_o) |-> $past(start_i) || $past(ecc_ack_i && !ecc_ok_i));

    p_ecc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ecc_req_o && !ecc_ack_i) |=> ecc_req_o);

    p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rd_req_o, ecc_req_o, done_o, fail_o}));

    p_done_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(ecc_ack_i && ecc_ok_i));

    p_fail_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fail_o) |-> $past(ecc_ack_i && !ecc_ok_i && cur_val == 2'b00));

    p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ecc_req_o && ecc_ack_i && !ecc_ok_i && cur_val != 2'b00)
        |=> rd_req_o && (cur_val == 2'($past(cur_val) - 2'd1)));

endmodule

bind nac_recovery_ctrl nac_recovery_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .ecc_req_o (ecc_req_o),
    .ecc_ack_i (ecc_ack_i),
    .ecc_ok_i  (ecc_ok_i),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .cur_val   (cur_val)
);

// File: tb/nac_recovery_ctrl_tb.sv
module nac_recovery_ctrl_tb;

    localparam int PAGE_BITS = 64;
    localparam int WORD_W    = 16;
    localparam int LVL_W     = 4;
    localparam int WORDS     = PAGE_BITS / WORD_W;
    localparam int AW        = $clog2(WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              lvl_we = 1'b0;
    logic [1:0]        lvl_idx = '0;
    logic [LVL_W-1:0]  lvl_val = '0;
    logic              buf_we = 1'b0;
    logic [1:0]        buf_sel = '0;
    logic [AW-1:0]     buf_addr = '0;
    logic [WORD_W-1:0] buf_wdata = '0;
    logic [AW-1:0]     page_raddr = '0;
    logic [WORD_W-1:0] page_rdata;
    logic              rd_req;
    logic [LVL_W-1:0]  rd_lvl;
    logic              rd_done = 1'b0;
    logic              ecc_req;
    logic              ecc_ack = 1'b0;
    logic              ecc_ok = 1'b0;
    logic              done;
    logic              fail;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [WORD_W-1:0] m_page [WORDS];
    logic [WORD_W-1:0] m_lsb  [WORDS];
    logic [WORD_W-1:0] m_msb  [WORDS];
    logic [LVL_W-1:0]  m_tbl  [4];

    always #10 clk = ~clk;

    nac_recovery_ctrl #(.PAGE_BITS(PAGE_BITS), .WORD_W(WORD_W), .LVL_W(LVL_W)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start),
        .lvl_we_i (lvl_we), .lvl_idx_i (lvl_idx), .lvl_val_i (lvl_val),
        .buf_we_i (buf_we), .buf_sel_i (buf_sel), .buf_addr_i (buf_addr),
        .buf_wdata_i (buf_wdata), .page_raddr_i (page_raddr),
        .page_rdata_o (page_rdata), .rd_req_o (rd_req), .rd_lvl_o (rd_lvl),
        .rd_done_i (rd_done), .ecc_req_o (ecc_req), .ecc_ack_i (ecc_ack),
        .ecc_ok_i (ecc_ok), .done_o (done), .fail_o (fail)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic wr_buf(input logic [1:0] sel, input int addr, input logic [WORD_W-1:0] d);
        buf_we = 1'b1; buf_sel = sel; buf_addr = AW'(addr); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic wr_lvl(input int idx, input logic [LVL_W-1:0] v);
        lvl_we = 1'b1; lvl_idx = 2'(idx); lvl_val = v; m_tbl[idx] = v;
        @(negedge clk);
        lvl_we = 1'b0;
    endtask

    task automatic load_page(input logic [WORD_W-1:0] seed);
        for (int w = 0; w < WORDS; w++) begin
            m_page[w] = seed ^ WORD_W'(w * 16'h0101);
            m_lsb[w]  = 16'hCCCC ^ WORD_W'(w * 16'h1111);
            m_msb[w]  = 16'hAAAA ^ WORD_W'(w * 16'h0F0F);
            wr_buf(2'd0, w, m_page[w]);
            wr_buf(2'd1, w, m_lsb[w]);
            wr_buf(2'd2, w, m_msb[w]);
        end
    endtask

    task automatic cmp_page(input string req);
        for (int w = 0; w < WORDS; w++) begin
            page_raddr = AW'(w);
            #1;
            chk(page_rdata === m_page[w], req, 32'(page_rdata), 32'(m_page[w]));
        end
    endtask

    // pass_at: trial index whose ECC reports success; 4 means never
    task automatic run_recovery(input int pass_at, input logic [WORD_W-1:0] rseed);
        int n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !fail, "R8 terminal flags cleared by start", {30'd0, done, fail}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            logic [1:0] v;
            logic [WORD_W-1:0] rr;
            v = ~2'(a);
            n = 0;
            while (!rd_req && n < 50) begin n++; @(negedge clk); end
            chk(rd_req === 1'b1, "R2 request issued for next value", 32'(rd_req), 32'd1);
            chk(rd_lvl === m_tbl[v], "R3 level from table entry of value", 32'(rd_lvl), 32'(m_tbl[v]));
            @(negedge clk);
            chk(rd_req === 1'b0, "R3 single-cycle request", 32'(rd_req), 32'd0);
            for (int w = 0; w < WORDS; w++) begin
                rr = rseed ^ WORD_W'(a * 16'h1357) ^ WORD_W'(w * 16'h2468);
                wr_buf(2'd3, w, rr);
                for (int i = 0; i < WORD_W; i++) begin
                    if (m_lsb[w][i] == v[1] && m_msb[w][i] == v[0]) m_page[w][i] = rr[i];
                end
            end
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
            n = 0;
            while (!ecc_req && n < 50) begin n++; @(negedge clk); end
            chk(n == WORDS, "R5 merge length in cycles", 32'(n), 32'(WORDS));
            cmp_page("R4 merged page contents");
            @(negedge clk);
            chk(ecc_req === 1'b1, "R5 ecc request held until ack", 32'(ecc_req), 32'd1);
            ecc_ack = 1'b1; ecc_ok = (a == pass_at);
            @(negedge clk);
            ecc_ack = 1'b0; ecc_ok = 1'b0;
            if (a == pass_at) begin
                chk(done === 1'b1 && fail === 1'b0, "R6 done after passing decode", {30'd0, done, fail}, 32'd2);
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    if (rd_req) chk(1'b0, "R6 no request after done", 32'd1, 32'd0);
                end
                chk(done === 1'b1, "R6 done held", 32'(done), 32'd1);
                cmp_page("R6 merged page readable after done");
                return;
            end else if (a == 3) begin
                chk(fail === 1'b1 && done === 1'b0, "R7 fail after fourth failure", {30'd0, done, fail}, 32'd1);
                cmp_page("R7 last merged page kept");
            end
        end
    endtask

    task automatic t_reset();
        chk(!rd_req && !ecc_req && !done && !fail, "R1 reset outputs low",
            {28'd0, rd_req, ecc_req, done, fail}, 32'd0);
    endtask

    task automatic t_idle();
        load_page(16'h5A3C);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rd_req || ecc_req) chk(1'b0, "R1 no activity without start", {30'd0, rd_req, ecc_req}, 32'd0);
        end
        chk(!rd_req && !ecc_req && !done && !fail, "R1 idle after buffer writes",
            {28'd0, rd_req, ecc_req, done, fail}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_tbl[i] = LVL_W'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        // R3 programmed table
        wr_lvl(3, 4'd5); wr_lvl(2, 4'd9); wr_lvl(1, 4'd12); wr_lvl(0, 4'd3);
        // first value passes
        run_recovery(0, 16'hF00F);
        // R8 restart from done, passes on value 01
        load_page(16'h1234);
        run_recovery(2, 16'h0FF0);
        // R7 every value fails
        load_page(16'h9876);
        run_recovery(4, 16'h3C3C);
        // R8 restart after fail with a reprogrammed table
        wr_lvl(2, 4'd14); wr_lvl(3, 4'd7);
        load_page(16'hBEEF);
        run_recovery(1, 16'h7E81);
        finish_run();
    end

endmodule